// File: doc/BRIEF.md
# Speculative Return Address Stack

This block predicts the targets of function returns for a fetch stage that runs ahead of execution. When fetch predicts a taken call, the stack pushes the address of the instruction after the call. When it predicts a return, the current top entry is used as the target, and the stack is then popped. The stack is circular. It never stalls. A push into a full stack overwrites the oldest entry, and a pop from an empty stack leaves the stale top value visible.

Fetch runs down wrong paths, so every speculative operation can be undone exactly. The stack shows its top index and top entry at all times. Fetch saves both with each predicted call or return. A return records the index and the target it consumed. When a squash reaches that return, the repair port writes the saved target back at the saved index and moves the top pointer there. When a squash reaches a call that pushed, the repair port pops one entry. Only one thread is supported.

All pins are plain level controls that are sampled on the rising clock edge. The block accepts every command in the cycle it is presented, so there is no valid/ready handshake and no back-pressure. The read side, the top index and the top entry, is combinational from state and is valid in every cycle.

Top module: `ras_spec_stack`

## Requirements
- R1: After reset the top index is 0, the occupancy is 0 and the top entry reads 0.
- R2: A push alone (call_valid=1, all other commands 0) stores call_pc + INST_BYTES at the next index, modulo DEPTH. In the next cycle that entry is on pred_target, top_idx has advanced by one, and occupancy has risen by one.
- R3: With DELAY_SLOT=1, a pushed entry is call_pc + 2*INST_BYTES.
- R4: A pop alone (ret_valid=1) moves top_idx back by one and lowers occupancy by one. pred_target then shows the entry that was below the popped one, so entries come back in last-in, first-out order.
- R5: A push and a pop in the same cycle act as a pop followed by a push. The top entry is replaced by the new return address and top_idx is unchanged. Occupancy is unchanged, except that it becomes 1 when it was 0.
- R6: A push when occupancy equals DEPTH overwrites the oldest entry and occupancy stays at DEPTH. The top index wraps from DEPTH-1 to 0.
- R7: A pop when occupancy is 0 keeps occupancy at 0 and still moves top_idx back by one, wrapping from 0 to DEPTH-1. pred_target then shows whatever value is stored at that index.
- R8: A restore (fix_restore=1) writes fix_target into entry fix_idx, sets top_idx to fix_idx, and raises occupancy by one, saturating at DEPTH. It takes priority over call_valid, ret_valid and fix_undo_push in the same cycle.
- R9: An undo-push (fix_undo_push=1) moves top_idx back by one and lowers occupancy by one, saturating at 0. It takes priority over call_valid and ret_valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_valid | input | 1 | Predicted-taken call: push its return address |
| call_pc | input | AW | Address of the call instruction |
| ret_valid | input | 1 | Predicted return: pop the top entry |
| fix_restore | input | 1 | Repair: restore a saved index and target |
| fix_idx | input | IW | Saved top index to restore |
| fix_target | input | AW | Saved target to write back |
| fix_undo_push | input | 1 | Repair: remove one speculative push |
| pred_target | output | AW | Current top entry (return target / popped value checkpoint) |
| top_idx | output | IW | Current top index (checkpoint) |
| occupancy | output | CW | Number of valid entries, 0 to DEPTH |

## Verification
The hardest state to reach from the ports is the wrapped stack: more pushes than DEPTH, so that the oldest entry is overwritten and the pointer has gone all the way round, followed by pops past empty into stale data. The bench reaches it with a directed burst of DEPTH+1 pushes, each carrying a distinct address. It then pops until the stack is empty and pops once more. Each expected stale value can be predicted from which push last wrote that slot. A second hazard is priority between repair and speculative commands that collide in one cycle. The vector table drives restore, undo, push and pop together in several combinations and checks that the higher-priority command alone took effect.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [2:0] {
    RAS_IDLE,
    RAS_PUSH,
    RAS_POP,
    RAS_SWAP,
    RAS_RESTORE,
    RAS_UNDO
  } ras_op_e;

  // Priority: restore, then undo, then the speculative push/pop pair.
  function automatic ras_op_e decode_op(input logic push, input logic pop,
                                        input logic restore, input logic undo);
    ras_op_e op;
    if (restore)          op = RAS_RESTORE;
    else if (undo)        op = RAS_UNDO;
    else if (push && pop) op = RAS_SWAP;
    else if (push)        op = RAS_PUSH;
    else if (pop)         op = RAS_POP;
    else                  op = RAS_IDLE;
    return op;
  endfunction

  function automatic int unsigned ret_offset(input int unsigned delay_slot,
                                             input int unsigned inst_bytes);
    return (delay_slot != 0) ? 2 * inst_bytes : inst_bytes;
  endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ras_op_e       op,
  input  logic [IW-1:0] fix_idx,
  output logic [IW-1:0] tos,
  output logic [CW-1:0] occ,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic          wr_from_fix
);

  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [IW-1:0] tos_inc, tos_dec, tos_nxt;
  logic [CW-1:0] occ_inc, occ_dec, occ_nxt;

  assign tos_inc = (tos == LAST_IDX) ? '0 : tos + 1'b1;
  assign tos_dec = (tos == '0) ? LAST_IDX : tos - 1'b1;
  assign occ_inc = (occ == FULL_CNT) ? occ : occ + 1'b1;
  assign occ_dec = (occ == '0) ? occ : occ - 1'b1;

  always_comb begin
    tos_nxt     = tos;
    occ_nxt     = occ;
    wr_en       = 1'b0;
    wr_idx      = tos;
    wr_from_fix = 1'b0;
    unique case (op)
      RAS_RESTORE: begin
        tos_nxt     = fix_idx;
        occ_nxt     = occ_inc;
        wr_en       = 1'b1;
        wr_idx      = fix_idx;
        wr_from_fix = 1'b1;
      end
      RAS_UNDO, RAS_POP: begin
        tos_nxt = tos_dec;
        occ_nxt = occ_dec;
      end
      RAS_PUSH: begin
        tos_nxt = tos_inc;
        occ_nxt = occ_inc;
        wr_en   = 1'b1;
        wr_idx  = tos_inc;
      end
      RAS_SWAP: begin
        occ_nxt = (occ == '0) ? CW'(1) : occ;
        wr_en   = 1'b1;
        wr_idx  = tos;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos <= '0;
      occ <= '0;
    end else begin
      tos <= tos_nxt;
      occ <= occ_nxt;
    end
  end

  // R6: occupancy never exceeds the stack depth
  p_occ_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_CNT);

  // R6: pushing into a full stack keeps it full and wraps the pointer
  p_full_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RAS_PUSH && occ == FULL_CNT) |=> (occ == FULL_CNT));

  // R7: popping an empty stack leaves it empty
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RAS_POP && occ == '0) |=> (occ == '0));

endmodule

// File: rtl/ras_entry_store.sv
module ras_entry_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 32,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data
);

  logic [AW-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            slot[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))    slot[g] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];

endmodule

// File: rtl/ras_spec_stack.sv
module ras_spec_stack
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned AW         = 32,
  parameter int unsigned INST_BYTES = 4,
  parameter int unsigned DELAY_SLOT = 0,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_valid,
  input  logic [AW-1:0] call_pc,
  input  logic          ret_valid,
  input  logic          fix_restore,
  input  logic [IW-1:0] fix_idx,
  input  logic [AW-1:0] fix_target,
  input  logic          fix_undo_push,
  output logic [AW-1:0] pred_target,
  output logic [IW-1:0] top_idx,
  output logic [CW-1:0] occupancy
);

  localparam logic [AW-1:0] RET_OFS = AW'(ret_offset(DELAY_SLOT, INST_BYTES));

  ras_op_e       op;
  logic          wr_en, wr_from_fix;
  logic [IW-1:0] wr_idx;
  logic [AW-1:0] push_addr, wr_data;

  assign op        = decode_op(call_valid, ret_valid, fix_restore, fix_undo_push);
  assign push_addr = call_pc + RET_OFS;
  assign wr_data   = wr_from_fix ? fix_target : push_addr;

  ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .fix_idx     (fix_idx),
    .tos         (top_idx),
    .occ         (occupancy),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_from_fix (wr_from_fix)
  );

  ras_entry_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (top_idx),
    .rd_data (pred_target)
  );

  // R2/R3: after a lone push the new top holds the return address
  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (call_valid && !ret_valid && !fix_restore && !fix_undo_push)
      |=> (pred_target == $past(call_pc) + RET_OFS));

  // R5: push with pop keeps the index and replaces the top
  p_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (call_valid && ret_valid && !fix_restore && !fix_undo_push)
      |=> (top_idx == $past(top_idx) && pred_target == $past(call_pc) + RET_OFS));

  // R8: restore wins and lands the saved index and target
  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fix_restore |=> (top_idx == $past(fix_idx) && pred_target == $past(fix_target)));

  // R9: undo-push steps the index back by one regardless of push/pop
  p_undo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_undo_push && !fix_restore) |=> (top_idx == IW'($past(top_idx) - 1'b1)));

  // R4: a lone pop on a non-empty stack lowers occupancy by one
  p_pop_occ_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !call_valid && !fix_restore && !fix_undo_push && occupancy != '0)
      |=> (occupancy == $past(occupancy) - 1'b1));

endmodule

// File: tb/ras_spec_stack_test.sv
`timescale 1ns/1ps
module ras_spec_stack_test;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW    = 32;
  localparam int unsigned IW    = $clog2(DEPTH);
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call_valid = 1'b0, ret_valid = 1'b0;
  logic          fix_restore = 1'b0, fix_undo_push = 1'b0;
  logic [AW-1:0] call_pc = '0, fix_target = '0;
  logic [IW-1:0] fix_idx = '0;
  logic [AW-1:0] pred_target, ds_target;
  logic [IW-1:0] top_idx, ds_idx;
  logic [CW-1:0] occupancy, ds_occ;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ras_spec_stack #(.DEPTH(DEPTH), .AW(AW), .INST_BYTES(4), .DELAY_SLOT(0)) uut (
    .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .call_pc(call_pc),
    .ret_valid(ret_valid), .fix_restore(fix_restore), .fix_idx(fix_idx),
    .fix_target(fix_target), .fix_undo_push(fix_undo_push),
    .pred_target(pred_target), .top_idx(top_idx), .occupancy(occupancy));

  ras_spec_stack #(.DEPTH(DEPTH), .AW(AW), .INST_BYTES(4), .DELAY_SLOT(1)) uut_ds (
    .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .call_pc(call_pc),
    .ret_valid(ret_valid), .fix_restore(fix_restore), .fix_idx(fix_idx),
    .fix_target(fix_target), .fix_undo_push(fix_undo_push),
    .pred_target(ds_target), .top_idx(ds_idx), .occupancy(ds_occ));

  typedef struct packed {
    logic          push;
    logic          pop;
    logic          rest;
    logic          undo;
    logic [AW-1:0] pc;
    logic [IW-1:0] ridx;
    logic [AW-1:0] rval;
    logic [IW-1:0] e_idx;
    logic [CW-1:0] e_occ;
    logic [AW-1:0] e_tgt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0, 32'h100, 4'd0, 32'h0,   4'd1, 5'd1, 32'h104}, // R2
    '{1'b1,1'b0,1'b0,1'b0, 32'h200, 4'd0, 32'h0,   4'd2, 5'd2, 32'h204}, // R2
    '{1'b1,1'b0,1'b0,1'b0, 32'h300, 4'd0, 32'h0,   4'd3, 5'd3, 32'h304}, // R2
    '{1'b0,1'b1,1'b0,1'b0, 32'h0,   4'd0, 32'h0,   4'd2, 5'd2, 32'h204}, // R4
    '{1'b1,1'b1,1'b0,1'b0, 32'h500, 4'd0, 32'h0,   4'd2, 5'd2, 32'h504}, // R5
    '{1'b0,1'b1,1'b0,1'b0, 32'h0,   4'd0, 32'h0,   4'd1, 5'd1, 32'h104}, // R4
    '{1'b0,1'b0,1'b1,1'b0, 32'h0,   4'd2, 32'h504, 4'd2, 5'd2, 32'h504}, // R8
    '{1'b1,1'b0,1'b0,1'b0, 32'h700, 4'd0, 32'h0,   4'd3, 5'd3, 32'h704}, // R2
    '{1'b0,1'b0,1'b0,1'b1, 32'h0,   4'd0, 32'h0,   4'd2, 5'd2, 32'h504}, // R9
    '{1'b1,1'b1,1'b1,1'b0, 32'h900, 4'd1, 32'hAAA, 4'd1, 5'd3, 32'hAAA}, // R8
    '{1'b1,1'b0,1'b0,1'b1, 32'hB00, 4'd0, 32'h0,   4'd0, 5'd2, 32'h0},   // R9
    '{1'b0,1'b0,1'b1,1'b1, 32'h0,   4'd5, 32'h55,  4'd5, 5'd3, 32'h55}   // R8
  };

  task automatic check(input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [IW-1:0] e_idx,
                             input logic [CW-1:0] e_occ, input logic [AW-1:0] e_tgt);
    check({req, " top_idx"},     AW'(top_idx),   AW'(e_idx));
    check({req, " occupancy"},   AW'(occupancy), AW'(e_occ));
    check({req, " pred_target"}, pred_target,    e_tgt);
  endtask

  // Drive at the falling edge, let one rising edge act, sample just after it.
  task automatic step(input logic push, input logic pop, input logic rest,
                      input logic undo, input logic [AW-1:0] pc,
                      input logic [IW-1:0] ridx, input logic [AW-1:0] rval);
    @(negedge clk);
    call_valid = push; ret_valid = pop; fix_restore = rest; fix_undo_push = undo;
    call_pc = pc; fix_idx = ridx; fix_target = rval;
    @(posedge clk);
    #1;
    call_valid = 1'b0; ret_valid = 1'b0; fix_restore = 1'b0; fix_undo_push = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    check_state("R1", '0, '0, '0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].push, TBL[i].pop, TBL[i].rest, TBL[i].undo,
           TBL[i].pc, TBL[i].ridx, TBL[i].rval);
      check_state($sformatf("vector %0d", i), TBL[i].e_idx, TBL[i].e_occ, TBL[i].e_tgt);
    end

    // R1: reset clears pointer, count and entries
    do_reset();
    check_state("R1 re-reset", '0, '0, '0);

    // R3: delay-slot variant pushes pc + 8
    step(1'b1, 1'b0, 1'b0, 1'b0, 32'h100, '0, '0);
    check("R3 delay-slot target", ds_target, 32'h108);
    check("R2 plain target", pred_target, 32'h104);

    // R6: fill past capacity; push k stores k*16+4 at index k mod DEPTH
    do_reset();
    for (int k = 1; k <= DEPTH + 1; k++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, AW'(k * 16), '0, '0);
      if (k == DEPTH) check_state("R6 wrap to 0", '0, CW'(DEPTH), AW'(DEPTH * 16 + 4));
    end
    check_state("R6 overwrite oldest", IW'(1), CW'(DEPTH), AW'((DEPTH + 1) * 16 + 4));

    // R4: pop back down; after the first pop the top is index 0
    step(1'b0, 1'b1, 1'b0, 1'b0, '0, '0, '0);
    check_state("R4 lifo", '0, CW'(DEPTH - 1), AW'(DEPTH * 16 + 4));
    for (int k = 0; k < DEPTH - 1; k++) step(1'b0, 1'b1, 1'b0, 1'b0, '0, '0, '0);
    check("R7 drained occupancy", AW'(occupancy), '0);
    check("R7 drained index", AW'(top_idx), 32'd1);

    // R7: pop while empty: count stays 0, index wraps back, stale value shows
    step(1'b0, 1'b1, 1'b0, 1'b0, '0, '0, '0);
    check_state("R7 empty pop", '0, '0, AW'(DEPTH * 16 + 4));
    step(1'b0, 1'b1, 1'b0, 1'b0, '0, '0, '0);
    check_state("R7 wrap under", IW'(DEPTH - 1), '0, AW'((DEPTH - 1) * 16 + 4));

    // R5: push with pop on an empty stack yields one entry
    step(1'b1, 1'b1, 1'b0, 1'b0, 32'hC00, '0, '0);
    check_state("R5 swap empty", IW'(DEPTH - 1), CW'(1), 32'hC04);

    // R9: undo on a one-entry stack, then undo saturates at zero
    step(1'b0, 1'b0, 1'b0, 1'b1, '0, '0, '0);
    check_state("R9 undo", IW'(DEPTH - 2), '0, AW'((DEPTH - 2) * 16 + 4));
    step(1'b0, 1'b1, 1'b0, 1'b1, '0, '0, '0);
    check("R9 undo saturates", AW'(occupancy), '0);

    finish_run();
  end

endmodule